// File: doc/BRIEF.md
# I2C Target with Word-Addressed Byte Buffers

This block is the target (slave) end of an I2C bus, built for a local CPU that works in 32-bit words. The bus controller addresses it with a 7-bit device address, which the CPU can program. Bytes the controller writes are collected in a receive buffer. Bytes the controller reads are shifted out of a transmit buffer that the CPU fills ahead of time. Each buffer holds 64 bytes and the CPU sees each one as sixteen words, with four bytes packed into every word.

Progress is visible through two counters. The receive pointer counts stored bytes and wraps at the buffer size, so the CPU can find new data by comparing it with the value it read last time. The transmit position counts bits handed to the bus. Three events latch status bits: a read transfer starting, a read transfer ending, and a write transfer with data ending. Each status bit has its own enable and is cleared by writing 1 to it. The block never stretches SCL and only pulls SDA low.

Top module: `i2c_target_wbuf`

## Requirements
- R1: After reset the following values hold: receive pointer (word address 32) is 0, transmit position (33) is 0, device address (34) is 0x50, interrupt enable (35) is 0, interrupt status (36) is 0, `irq` is 0, and SDA is released.
- R2: The first byte after a START is {address[6:0], rw}. If the address equals the device address, the block pulls SDA low in the ninth clock (ACK). Otherwise it leaves SDA high (NACK), and ignores the rest of that transfer, so nothing is stored and no status bit is set.
- R3: In a matched write (rw=0), every data byte is ACKed and stored at the receive pointer, which then increments. Stream byte n sits in receive word n/4 (word addresses 0..15) at bits 8*(n mod 4)+7 : 8*(n mod 4).
- R4: The receive pointer wraps modulo 64, and bytes past the wrap overwrite the buffer from byte 0.
- R5: In a matched read (rw=1), the block sends the transmit-buffer byte at the current transmit position, MSB first. The transmit buffer is written and read by the CPU at word addresses 16..31, with the same byte packing as R3.
- R6: The transmit position increments by one for every bit driven and wraps modulo 512. After the controller NACKs a byte, SDA stays released until the next START or STOP.
- R7: Status bit 0 (write end) is set by a STOP or repeated START that ends a matched write which carried at least one data byte. A write with no data byte leaves it clear.
- R8: Status bit 1 (read start) is set when a read address is matched. Status bit 2 (read end) is set by the STOP or repeated START that ends a matched read.
- R9: `irq` is high exactly when some status bit and its enable bit (same position) are both 1. Writing the status word clears the bits written as 1 and leaves the other bits unchanged.
- R10: A CPU write to word address 34 replaces the device address (bits 6:0). From the next transfer on, only the new address is matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen at the pad |
| sdaIn | input | 1 | SDA level seen at the pad |
| sdaPullLow | output | 1 | 1 enables the pad's pull-down on SDA |
| regAddr | input | 6 | CPU word address |
| regWrEn | input | 1 | CPU write strobe |
| regWrData | input | 32 | CPU write data |
| regRdData | output | 32 | CPU read data for regAddr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Write transfers use random lengths and random data. Comparing the packed receive words against a byte model exposes wrong lane order and pointer slips. A long burst that crosses the 64-byte boundary shows whether the pointer and the storage wrap together. Reads with ACK/ACK/NACK endings, followed by a full 64-byte read, separate correct MSB-first ordering and bit-exact position counting from errors of one bit or one byte. A foreign address, a write with no data, a repeated START between a write and a read, and a reprogrammed address each isolate one condition for ACK or for setting a status bit.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int IRQ_N = 3;
  localparam int IRQ_WREND = 0;
  localparam int IRQ_RDSTART = 1;
  localparam int IRQ_RDEND = 2;
  localparam int OFS_WPTR = 0;
  localparam int OFS_TXPOS = 1;
  localparam int OFS_DEV = 2;
  localparam int OFS_IEN = 3;
  localparam int OFS_IST = 4;
  localparam logic [6:0] DEF_DEV_ADDR = 7'h50;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  typedef struct packed {
    logic       rxPush;
    logic [7:0] rxByte;
    logic       txAdv;
    logic       wrEnd;
    logic       rdStart;
    logic       rdEnd;
  } ctlStrobe_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '1;
      else if (s == 0) pipe[s] <= din;
      else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [6:0] devAddr,
  input  logic       txBitNow,
  output ctlStrobe_t stb,
  output logic       sdaLow
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  busState_t  st;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       sclPrev, sdaPrev, rwBit, ackN, inWr, inRd, gotData;
  logic       sclRise, sclFall, startCond, stopCond, busEvt, byteDone, addrHit;

  always_comb begin
    sclRise   = sclS & ~sclPrev;
    sclFall   = ~sclS & sclPrev;
    startCond = sclS & sclPrev & sdaPrev & ~sdaS;
    stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;
    busEvt    = startCond | stopCond;
    byteDone  = sclFall && (bitCnt == BYTE_BITS);
    addrHit   = (shReg[7:1] == devAddr);
  end

  always_comb begin
    stb.rxPush  = (st == ST_WR) && byteDone;
    stb.rxByte  = shReg;
    stb.rdStart = (st == ST_ADDR) && byteDone && addrHit && shReg[0];
    stb.wrEnd   = busEvt && inWr && gotData;
    stb.rdEnd   = busEvt && inRd;
    stb.txAdv   = sclFall && (((st == ST_ADDR_ACK) && rwBit) ||
                              ((st == ST_RD) && (bitCnt != BYTE_BITS)) ||
                              ((st == ST_RD_ACK) && !ackN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      bitCnt <= '0;
      shReg <= '0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      rwBit <= 1'b0;
      ackN <= 1'b1;
      inWr <= 1'b0;
      inRd <= 1'b0;
      gotData <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (busEvt) begin
        st <= startCond ? ST_ADDR : ST_IDLE;
        bitCnt <= '0;
        sdaLow <= 1'b0;
        inWr <= 1'b0;
        inRd <= 1'b0;
        gotData <= 1'b0;
      end else begin
        if (stb.txAdv) sdaLow <= ~txBitNow;
        case (st)
          ST_ADDR: begin
            if (sclRise) begin
              shReg <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (byteDone) begin
              if (addrHit) begin
                st <= ST_ADDR_ACK;
                sdaLow <= 1'b1;
                rwBit <= shReg[0];
                inRd <= shReg[0];
                inWr <= ~shReg[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (rwBit) begin
                st <= ST_RD;
                bitCnt <= 4'd1;
              end else begin
                st <= ST_WR;
                bitCnt <= '0;
                sdaLow <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (sclRise) begin
              shReg <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (byteDone) begin
              st <= ST_WR_ACK;
              sdaLow <= 1'b1;
              gotData <= 1'b1;
            end
          end
          ST_WR_ACK: begin
            if (sclFall) begin
              st <= ST_WR;
              bitCnt <= '0;
              sdaLow <= 1'b0;
            end
          end
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == BYTE_BITS) begin
                st <= ST_RD_ACK;
                sdaLow <= 1'b0;
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              ackN <= sdaS;
            end else if (sclFall) begin
              if (ackN) begin
                st <= ST_IDLE;
              end else begin
                st <= ST_RD;
                bitCnt <= 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_dpath.sv
module i2ct_dpath
  import i2ct_pkg::*;
#(
  parameter  int BUF_BYTES = 64,
  localparam int WORDS  = BUF_BYTES / 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int RA_W   = WSEL_W + 2,
  localparam int PTR_W  = $clog2(BUF_BYTES),
  localparam int POS_W  = PTR_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic [RA_W-1:0]  regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic [6:0]       devAddr,
  output logic             txBitNow,
  output logic [PTR_W-1:0] rxPtr,
  output logic [POS_W-1:0] txPos,
  output logic [IRQ_N-1:0] irqState,
  output logic             irq
);
  localparam logic [RA_W-1:0] A_WPTR  = RA_W'(2 * WORDS + OFS_WPTR);
  localparam logic [RA_W-1:0] A_TXPOS = RA_W'(2 * WORDS + OFS_TXPOS);
  localparam logic [RA_W-1:0] A_DEV   = RA_W'(2 * WORDS + OFS_DEV);
  localparam logic [RA_W-1:0] A_IEN   = RA_W'(2 * WORDS + OFS_IEN);
  localparam logic [RA_W-1:0] A_IST   = RA_W'(2 * WORDS + OFS_IST);

  logic [7:0]        rxMem [BUF_BYTES];
  logic [7:0]        txMem [BUF_BYTES];
  logic [IRQ_N-1:0]  irqEn, setVec, clrVec;
  logic [WSEL_W-1:0] wIdx;
  logic              isBuf, isTx, txWordWr;

  always_comb begin
    wIdx     = regAddr[WSEL_W-1:0];
    isBuf    = ~regAddr[RA_W-1];
    isTx     = regAddr[WSEL_W];
    txWordWr = regWrEn && isBuf && isTx;
    setVec = '0;
    setVec[IRQ_WREND]   = stb.wrEnd;
    setVec[IRQ_RDSTART] = stb.rdStart;
    setVec[IRQ_RDEND]   = stb.rdEnd;
    clrVec = (regWrEn && (regAddr == A_IST)) ? regWrData[IRQ_N-1:0] : '0;
    txBitNow = txMem[txPos[POS_W-1:3]][3'd7 - txPos[2:0]];
    irq = |(irqState & irqEn);
  end

  always_comb begin
    regRdData = '0;
    if (isBuf) begin
      for (int l = 0; l < 4; l++)
        regRdData[8*l +: 8] = isTx ? txMem[{wIdx, 2'(l)}] : rxMem[{wIdx, 2'(l)}];
    end else begin
      case (regAddr)
        A_WPTR:  regRdData = 32'(rxPtr);
        A_TXPOS: regRdData = 32'(txPos);
        A_DEV:   regRdData = 32'(devAddr);
        A_IEN:   regRdData = 32'(irqEn);
        A_IST:   regRdData = 32'(irqState);
        default: regRdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) rxMem[i] <= '0;
      rxPtr <= '0;
    end else if (stb.rxPush) begin
      rxMem[rxPtr] <= stb.rxByte;
      rxPtr <= rxPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) txMem[i] <= '0;
    end else if (txWordWr) begin
      for (int l = 0; l < 4; l++) txMem[{wIdx, 2'(l)}] <= regWrData[8*l +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPos <= '0;
      devAddr <= DEF_DEV_ADDR;
      irqEn <= '0;
      irqState <= '0;
    end else begin
      if (stb.txAdv) txPos <= txPos + 1'b1;
      if (regWrEn && (regAddr == A_DEV)) devAddr <= regWrData[6:0];
      if (regWrEn && (regAddr == A_IEN)) irqEn <= regWrData[IRQ_N-1:0];
      irqState <= (irqState & ~clrVec) | setVec;
    end
  end
endmodule

// File: rtl/i2c_target_wbuf.sv
module i2c_target_wbuf
  import i2ct_pkg::*;
#(
  parameter  int BUF_BYTES = 64,
  localparam int RA_W = $clog2(BUF_BYTES / 4) + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output logic            sdaPullLow,
  input  logic [RA_W-1:0] regAddr,
  input  logic            regWrEn,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  output logic            irq
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int POS_W = PTR_W + 3;

  logic             sclS, sdaS, txBitNow;
  logic [6:0]       devAddr;
  ctlStrobe_t       ctlStb;
  logic [PTR_W-1:0] rxPtr;
  logic [POS_W-1:0] txPos;
  logic [IRQ_N-1:0] irqState;

  i2ct_sync #(.STAGES(2), .W(2)) u_sync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout({sclS, sdaS})
  );

  i2ct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .devAddr(devAddr),
    .txBitNow(txBitNow), .stb(ctlStb), .sdaLow(sdaPullLow)
  );

  i2ct_dpath #(.BUF_BYTES(BUF_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .devAddr(devAddr),
    .txBitNow(txBitNow), .rxPtr(rxPtr), .txPos(txPos), .irqState(irqState), .irq(irq)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
#(
  parameter  int BUF_BYTES = 64,
  localparam int RA_W  = $clog2(BUF_BYTES / 4) + 2,
  localparam int PTR_W = $clog2(BUF_BYTES),
  localparam int POS_W = PTR_W + 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxPush,
  input logic             txAdv,
  input logic             wrEnd,
  input logic             rdStart,
  input logic             rdEnd,
  input logic             sclS,
  input logic             sdaPullLow,
  input logic [PTR_W-1:0] rxPtr,
  input logic [POS_W-1:0] txPos,
  input logic [IRQ_N-1:0] irqState,
  input logic [RA_W-1:0]  regAddr,
  input logic             regWrEn,
  input logic [IRQ_N-1:0] wrLow
);
  localparam logic [RA_W-1:0] A_IST = RA_W'(2 * (BUF_BYTES / 4) + OFS_IST);

  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxPush |=> $stable(rxPtr));
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> rxPtr == PTR_W'($past(rxPtr) + 1'b1));
  a_r6_pos_step: assert property (@(posedge clk) disable iff (!rstN)
    txAdv |=> txPos == POS_W'($past(txPos) + 1'b1));
  a_r6_pos_hold: assert property (@(posedge clk) disable iff (!rstN)
    !txAdv |=> $stable(txPos));
  a_r7_wrend_latch: assert property (@(posedge clk) disable iff (!rstN)
    wrEnd |=> irqState[IRQ_WREND]);
  a_r8_rdstart_latch: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |=> irqState[IRQ_RDSTART]);
  a_r8_rdend_latch: assert property (@(posedge clk) disable iff (!rstN)
    rdEnd |=> irqState[IRQ_RDEND]);
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_IST && !(wrEnd || rdStart || rdEnd))
      |=> (irqState & $past(wrLow)) == '0);
endmodule

bind i2c_target_wbuf i2ct_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .rxPush(ctlStb.rxPush), .txAdv(ctlStb.txAdv),
  .wrEnd(ctlStb.wrEnd), .rdStart(ctlStb.rdStart), .rdEnd(ctlStb.rdEnd),
  .sclS(sclS), .sdaPullLow(sdaPullLow), .rxPtr(rxPtr), .txPos(txPos),
  .irqState(irqState), .regAddr(regAddr), .regWrEn(regWrEn),
  .wrLow(regWrData[i2ct_pkg::IRQ_N-1:0])
);

// File: tb/tb_i2c_target_wbuf.sv
`timescale 1ns/100ps
module tb_i2c_target_wbuf;
  localparam int RA_W = 6;
  localparam int A_WPTR = 32, A_TXPOS = 33, A_DEV = 34, A_IEN = 35, A_IST = 36;
  localparam int TX_BASE = 16;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic regWrEn = 1'b0;
  logic [RA_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  wire [31:0] regRdData;
  wire sdaPullLow, irq;
  wire sdaLine = sdaM & ~sdaPullLow;

  i2c_target_wbuf dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] rxModel [64];
  logic [7:0] txModel [64];
  int rxPtrM = 0, txPosM = 0;

  function automatic logic [31:0] packWord(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (8) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic s);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    s = sdaLine;
    sclM = 1'b0; waitQ();
  endtask

  task automatic doStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic doStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(d[i], s);
    sendBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic readByte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, s);
      d[i] = s;
    end
    sendBit(nack, s);
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = RA_W'(a);
    #1 d = regRdData;
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = RA_W'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkRxWords(input string req);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      regRead(w, d);
      check(req, "rx word", d, packWord(rxModel[4*w], rxModel[4*w+1], rxModel[4*w+2], rxModel[4*w+3]));
    end
  endtask

  task automatic writeData(input int n, input string req);
    logic ack;
    logic [7:0] b;
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      writeByte(b, ack);
      if (!ack) bad++;
      rxModel[rxPtrM] = b;
      rxPtrM = (rxPtrM + 1) % 64;
    end
    check(req, "data bytes NACKed", bad, 0);
  endtask

  task automatic readData(input int n, input string req);
    logic [7:0] d;
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      readByte(i == n - 1, d);
      if (d !== txModel[(txPosM / 8) % 64]) bad++;
      txPosM = (txPosM + 8) % 512;
    end
    check(req, "read bytes mismatched", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ack, s;
    int n;
    int unsigned seedV;
    logic [6:0] newAddr;
    seedV = $urandom(32'h5EED_1C2);
    for (int i = 0; i < 64; i++) begin rxModel[i] = '0; txModel[i] = '0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    regRead(A_WPTR, d);  check("R1", "wptr", d, 0);
    regRead(A_TXPOS, d); check("R1", "txpos", d, 0);
    regRead(A_DEV, d);   check("R1", "devaddr", d, 32'h50);
    regRead(A_IEN, d);   check("R1", "irq enable", d, 0);
    regRead(A_IST, d);   check("R1", "irq state", d, 0);
    check("R1", "irq", {31'd0, irq}, 0);
    check("R1", "sda pull", {31'd0, sdaPullLow}, 0);

    // R2/R3/R7 random-length write
    n = 1 + int'($urandom % 8);
    doStart();
    writeByte({7'h50, 1'b0}, ack); check("R2", "address ack", {31'd0, ack}, 1);
    writeData(n, "R3");
    doStop();
    regRead(A_WPTR, d); check("R3", "wptr after write", d, 32'(rxPtrM));
    checkRxWords("R3");
    regRead(A_IST, d); check("R7", "write end set", d, 32'h1);
    check("R9", "irq masked", {31'd0, irq}, 0);

    // R9 enable, mask and write-one-to-clear
    regWrite(A_IEN, 32'h4);
    check("R9", "irq other bit enabled", {31'd0, irq}, 0);
    regWrite(A_IEN, 32'h1);
    check("R9", "irq enabled", {31'd0, irq}, 1);
    regWrite(A_IST, 32'h6);
    regRead(A_IST, d); check("R9", "w1c keeps bit0", d, 32'h1);
    regWrite(A_IST, 32'h1);
    regRead(A_IST, d); check("R9", "w1c clears", d, 0);
    check("R9", "irq dropped", {31'd0, irq}, 0);
    regWrite(A_IEN, 32'h0);

    // R2 foreign address ignored
    doStart();
    writeByte({7'h51, 1'b0}, ack); check("R2", "foreign address nack", {31'd0, ack}, 0);
    writeByte(8'hA5, ack); check("R2", "data after nack", {31'd0, ack}, 0);
    doStop();
    regRead(A_WPTR, d); check("R2", "wptr unchanged", d, 32'(rxPtrM));
    regRead(A_IST, d); check("R2", "no status", d, 0);

    // R7 write with no data byte
    doStart();
    writeByte({7'h50, 1'b0}, ack);
    doStop();
    regRead(A_IST, d); check("R7", "empty write no status", d, 0);

    // R4 wrap across the buffer end
    n = 64 - rxPtrM + 1 + int'($urandom % 6);
    doStart();
    writeByte({7'h50, 1'b0}, ack);
    writeData(n, "R4");
    doStop();
    regRead(A_WPTR, d); check("R4", "wptr wrapped", d, 32'(rxPtrM));
    checkRxWords("R4");
    regWrite(A_IST, 32'h7);

    // R5 transmit buffer fill and readback
    for (int w = 0; w < 16; w++) begin
      d = $urandom;
      regWrite(TX_BASE + w, d);
      for (int l = 0; l < 4; l++) txModel[4*w + l] = d[8*l +: 8];
    end
    regRead(TX_BASE + 5, d);
    check("R5", "tx word readback", d, packWord(txModel[20], txModel[21], txModel[22], txModel[23]));

    // R5/R6/R8 read ACK, ACK, NACK
    doStart();
    writeByte({7'h50, 1'b1}, ack); check("R2", "read address ack", {31'd0, ack}, 1);
    regRead(A_IST, d); check("R8", "read start set", d, 32'h2);
    readData(3, "R5");
    regRead(A_TXPOS, d); check("R6", "txpos after 3 bytes", d, 32'(txPosM));
    n = 0;
    for (int i = 0; i < 8; i++) begin
      sendBit(1'b1, s);
      if (!s) n++;
    end
    check("R6", "sda released after nack", n, 0);
    doStop();
    regRead(A_IST, d); check("R8", "read end set", d, 32'h6);
    regWrite(A_IST, 32'h7);

    // R6 continuation and wrap modulo 512
    doStart();
    writeByte({7'h50, 1'b1}, ack);
    readData(2, "R6");
    doStop();
    doStart();
    writeByte({7'h50, 1'b1}, ack);
    readData(64, "R6");
    doStop();
    regRead(A_TXPOS, d); check("R6", "txpos wrapped", d, 32'(txPosM));
    regWrite(A_IST, 32'h7);

    // R7/R8 repeated START ending a write, then a read
    doStart();
    writeByte({7'h50, 1'b0}, ack);
    writeData(1, "R7");
    doStart();
    regRead(A_IST, d); check("R7", "write end on repeated start", d, 32'h1);
    writeByte({7'h50, 1'b1}, ack);
    readData(1, "R8");
    doStop();
    regRead(A_IST, d); check("R8", "read start and end", d, 32'h7);
    checkRxWords("R3");

    // R10 programmable device address
    newAddr = 7'($urandom);
    if (newAddr == 7'h50) newAddr = 7'h2C;
    regWrite(A_DEV, {25'd0, newAddr});
    regRead(A_DEV, d); check("R10", "devaddr readback", d, {25'd0, newAddr});
    doStart();
    writeByte({newAddr, 1'b0}, ack); check("R10", "new address ack", {31'd0, ack}, 1);
    writeData(2, "R10");
    doStop();
    doStart();
    writeByte({7'h50, 1'b0}, ack); check("R10", "old address nack", {31'd0, ack}, 0);
    doStop();
    regRead(A_WPTR, d); check("R10", "wptr", d, 32'(rxPtrM));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule